// File: doc/BRIEF.md
# UART Pin Path Router

This block sits between a UART core and its package pins and decides where each serial and modem signal travels. In normal operation the transmit shifter drives the TXD pin, the RXD pin feeds the receiver, and the modem lines pass between core and pins with the pins active-low. Three test routes can replace this. Local loopback turns the transmitter back into the receiver and closes the modem lines inside the block. Remote loopback sends whatever arrives on RXD back out on TXD with the receiver switched off. Automatic echo does the same while the receiver keeps listening.

The three mode bits come from a control register elsewhere. The block samples them into its own route register on each rising clock edge. The serial and modem paths themselves are combinational, so data bits cross the block without delay. Modem vectors use one bit per line: bit 0 pairs DTR with DSR, bit 1 pairs RTS with CTS, bit 2 pairs OUT1 with RI, and bit 3 pairs OUT2 with DCD.

Top module: `uart_path_router`

## Requirements
- R1: While `rstN` is low and after its release, until a test mode is captured, the route is normal.
- R2: The mode bits are sampled at a rising clock edge, and a new route takes effect only after that edge. Before the edge the previous route still applies.
- R3: Normal route: `txPin` follows `txShift`, `rxSerial` follows `rxPin`, and `rxEnable` is 1. Each `modemPinN[i]` is the inverse of `modemReq[i]`, and each `modemStat[i]` is the inverse of `modemPinIn[i]`. Internal signals are active-high and pins are active-low.
- R4: Local loopback (`modeLocal`=1): `txPin` is 1, `rxSerial` follows `txShift`, and `rxEnable` is 1. `rxPin` has no effect.
- R5: Local loopback: all four `modemPinN` bits are 1, each `modemStat[i]` equals `modemReq[i]` (DTR→DSR, RTS→CTS, OUT1→RI, OUT2→DCD), and `modemPinIn` has no effect.
- R6: Remote loopback (`modeRemote`=1, `modeLocal`=0): `txPin` follows `rxPin`, `rxEnable` is 0, `rxSerial` is held at 1 (idle), and `txShift` has no effect.
- R7: Automatic echo (`modeEcho`=1, other mode bits 0): `txPin` follows `rxPin`, `rxSerial` follows `rxPin`, and `rxEnable` is 1.
- R8: Priority order is local loopback, then remote loopback, then automatic echo. Normal applies when all three mode bits are 0.
- R9: In the remote loopback and automatic echo routes, the modem lines behave as in the normal route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the route register |
| rstN | input | 1 | Asynchronous active-low reset |
| modeLocal | input | 1 | Local loopback request |
| modeRemote | input | 1 | Remote loopback request |
| modeEcho | input | 1 | Automatic echo request |
| txShift | input | 1 | Serial output of the transmit shifter |
| rxPin | input | 1 | RXD pin |
| modemReq | input | 4 | Core modem outputs DTR, RTS, OUT1, OUT2 (active-high) |
| modemPinIn | input | 4 | Modem pins DSR, CTS, RI, DCD (active-low) |
| txPin | output | 1 | TXD pin |
| rxSerial | output | 1 | Serial input to the receiver |
| rxEnable | output | 1 | Receiver enable |
| modemPinN | output | 4 | Modem output pins (active-low) |
| modemStat | output | 4 | Modem status to the core (active-high) |

## Verification
Two things can land in the same cycle: several mode bits set together, and a route change arriving while serial and modem data are moving. The bench drives every combination of two or three mode bits and checks that only the winning route shapes all five outputs. It changes the mode bits together with the data just before an edge and confirms that the old route holds until the edge and the new one after it. Ignored inputs (pin modem lines in local loopback, `rxPin` in local loopback, `txShift` in remote loopback) are toggled while the outputs are watched for any change.

// File: rtl/uart_route_pkg.sv
package uart_route_pkg;
  localparam int MODEM_W = 4;

  typedef enum logic [1:0] {
    RM_NORMAL = 2'd0,
    RM_LOCAL  = 2'd1,
    RM_REMOTE = 2'd2,
    RM_ECHO   = 2'd3
  } routeMode_e;

  typedef struct packed {
    logic txForceHigh;
    logic txFromRx;
    logic rxFromTx;
    logic rxHoldIdle;
    logic rxEnable;
    logic modemLoop;
  } routeCtl_t;
endpackage

// File: rtl/uart_route_ctrl.sv
module uart_route_ctrl
  import uart_route_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      modeLocal,
  input  logic      modeRemote,
  input  logic      modeEcho,
  output routeCtl_t ctl
);
  routeMode_e nextMode;
  routeMode_e modeQ;
  logic       pastValid;

  // fixed priority: local, then remote, then echo
  always_comb begin
    if (modeLocal)       nextMode = RM_LOCAL;
    else if (modeRemote) nextMode = RM_REMOTE;
    else if (modeEcho)   nextMode = RM_ECHO;
    else                 nextMode = RM_NORMAL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= RM_NORMAL;
      pastValid <= 1'b0;
    end else begin
      modeQ     <= nextMode;
      pastValid <= 1'b1;
    end
  end

  always_comb begin
    ctl = '{txForceHigh: 1'b0, txFromRx: 1'b0, rxFromTx: 1'b0,
            rxHoldIdle: 1'b0, rxEnable: 1'b1, modemLoop: 1'b0};
    unique case (modeQ)
      RM_LOCAL: begin
        ctl.txForceHigh = 1'b1;
        ctl.rxFromTx    = 1'b1;
        ctl.modemLoop   = 1'b1;
      end
      RM_REMOTE: begin
        ctl.txFromRx   = 1'b1;
        ctl.rxHoldIdle = 1'b1;
        ctl.rxEnable   = 1'b0;
      end
      RM_ECHO: ctl.txFromRx = 1'b1;
      default: ;
    endcase
  end

  // R8: local wins whatever else was requested
  assert_local_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(modeLocal)) |-> (ctl.txForceHigh && ctl.modemLoop && !ctl.txFromRx));

  // R8: remote beats echo and turns the receiver off
  assert_remote_over_echo_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(!modeLocal && modeRemote)) |-> (!ctl.rxEnable && ctl.txFromRx));

  // R7: echo keeps the receiver on
  assert_echo_rx_on_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(!modeLocal && !modeRemote && modeEcho)) |-> (ctl.rxEnable && ctl.txFromRx && !ctl.modemLoop));

  // R1, R2: no request captured means the normal route
  assert_normal_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!pastValid || $past(!modeLocal && !modeRemote && !modeEcho)) |->
      (!ctl.txForceHigh && !ctl.txFromRx && !ctl.rxFromTx && ctl.rxEnable && !ctl.modemLoop));
endmodule

// File: rtl/uart_route_dpath.sv
module uart_route_dpath
  import uart_route_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  routeCtl_t          ctl,
  input  logic               txShift,
  input  logic               rxPin,
  input  logic [MODEM_W-1:0] modemReq,
  input  logic [MODEM_W-1:0] modemPinIn,
  output logic               txPin,
  output logic               rxSerial,
  output logic               rxEnable,
  output logic [MODEM_W-1:0] modemPinN,
  output logic [MODEM_W-1:0] modemStat
);
  always_comb begin
    if (ctl.txForceHigh)   txPin = 1'b1;
    else if (ctl.txFromRx) txPin = rxPin;
    else                   txPin = txShift;

    if (ctl.rxHoldIdle)    rxSerial = 1'b1;
    else if (ctl.rxFromTx) rxSerial = txShift;
    else                   rxSerial = rxPin;

    rxEnable = ctl.rxEnable;
  end

  for (genvar i = 0; i < MODEM_W; i++) begin : g_modem
    assign modemPinN[i] = ctl.modemLoop ? 1'b1 : ~modemReq[i];
    assign modemStat[i] = ctl.modemLoop ? modemReq[i] : ~modemPinIn[i];
  end

  // R5: pins released while the modem lines loop inside
  assert_pins_released_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.modemLoop |-> (&modemPinN && (modemStat == modemReq)));

  // R6: receiver off means line held idle and echoed out
  assert_rx_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |-> (rxSerial && (txPin == rxPin)));

  // R4: local loopback keeps the line high
  assert_tx_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rxFromTx |-> (txPin && (rxSerial == txShift)));
endmodule

// File: rtl/uart_path_router.sv
module uart_path_router
  import uart_route_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeLocal,
  input  logic               modeRemote,
  input  logic               modeEcho,
  input  logic               txShift,
  input  logic               rxPin,
  input  logic [MODEM_W-1:0] modemReq,
  input  logic [MODEM_W-1:0] modemPinIn,
  output logic               txPin,
  output logic               rxSerial,
  output logic               rxEnable,
  output logic [MODEM_W-1:0] modemPinN,
  output logic [MODEM_W-1:0] modemStat
);
  routeCtl_t ctl;

  uart_route_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .modeLocal(modeLocal), .modeRemote(modeRemote), .modeEcho(modeEcho),
    .ctl(ctl)
  );

  uart_route_dpath u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .txShift(txShift), .rxPin(rxPin),
    .modemReq(modemReq), .modemPinIn(modemPinIn),
    .txPin(txPin), .rxSerial(rxSerial), .rxEnable(rxEnable),
    .modemPinN(modemPinN), .modemStat(modemStat)
  );
endmodule

// File: tb/sim_uart_path_router.sv
module sim_uart_path_router;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeLocal = 1'b0, modeRemote = 1'b0, modeEcho = 1'b0;
  logic txShift = 1'b1, rxPin = 1'b1;
  logic [3:0] modemReq = 4'h0, modemPinIn = 4'hF;
  logic txPin, rxSerial, rxEnable;
  logic [3:0] modemPinN, modemStat;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_path_router u0 (.*);

  // {mode[2:0]=local,remote,echo, tx, rx, req, pin, expTx, expRxS, expEn, expPinN, expStat}
  localparam int NV = 12;
  localparam logic [23:0] VEC [NV] = '{
    {3'b000,1'b1,1'b0,4'b0101,4'b0011, 1'b1,1'b0,1'b1,4'b1010,4'b1100}, // R3
    {3'b000,1'b0,1'b1,4'b1010,4'b1111, 1'b0,1'b1,1'b1,4'b0101,4'b0000}, // R3
    {3'b100,1'b0,1'b1,4'b0110,4'b0000, 1'b1,1'b0,1'b1,4'b1111,4'b0110}, // R4 R5
    {3'b100,1'b1,1'b0,4'b1001,4'b1010, 1'b1,1'b1,1'b1,4'b1111,4'b1001}, // R4 R5
    {3'b010,1'b1,1'b0,4'b0011,4'b0110, 1'b0,1'b1,1'b0,4'b1100,4'b1001}, // R6 R9
    {3'b010,1'b0,1'b1,4'b0000,4'b1111, 1'b1,1'b1,1'b0,4'b1111,4'b0000}, // R6 R9
    {3'b001,1'b1,1'b0,4'b1100,4'b0101, 1'b0,1'b0,1'b1,4'b0011,4'b1010}, // R7 R9
    {3'b001,1'b0,1'b1,4'b0001,4'b1000, 1'b1,1'b1,1'b1,4'b1110,4'b0111}, // R7 R9
    {3'b110,1'b0,1'b0,4'b0000,4'b0000, 1'b1,1'b0,1'b1,4'b1111,4'b0000}, // R8
    {3'b111,1'b1,1'b1,4'b1111,4'b0000, 1'b1,1'b1,1'b1,4'b1111,4'b1111}, // R8
    {3'b011,1'b1,1'b0,4'b0100,4'b1011, 1'b0,1'b1,1'b0,4'b1011,4'b0100}, // R8
    {3'b101,1'b0,1'b1,4'b0010,4'b0100, 1'b1,1'b0,1'b1,4'b1111,4'b0010}  // R8
  };

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got tx/rxs/en/pinN/stat=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [10:0] outs();
    return {txPin, rxSerial, rxEnable, modemPinN, modemStat};
  endfunction

  task automatic setMode(input logic [2:0] m);
    {modeLocal, modeRemote, modeEcho} = m;
  endtask

  initial begin
    // R1: reset state, mode requests ignored while in reset
    setMode(3'b100); txShift = 1'b0; rxPin = 1'b1; modemReq = 4'b0011; modemPinIn = 4'b0101;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", outs(), {1'b0,1'b1,1'b1,4'b1100,4'b1010});
    setMode(3'b000);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 after release", outs(), {1'b0,1'b1,1'b1,4'b1100,4'b1010});

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      setMode(VEC[i][23:21]);
      txShift = VEC[i][20]; rxPin = VEC[i][19];
      modemReq = VEC[i][18:15]; modemPinIn = VEC[i][14:11];
      @(posedge clk); #5;
      check($sformatf("R3-R9 row %0d", i), outs(), VEC[i][10:0]);
    end

    // R2: new route waits for the edge
    @(negedge clk); setMode(3'b000);
    @(posedge clk); @(negedge clk);
    txShift = 1'b0; rxPin = 1'b1; modemReq = 4'b0000; modemPinIn = 4'b1111;
    setMode(3'b100);
    #5 check("R2 before edge", outs(), {1'b0,1'b1,1'b1,4'b1111,4'b0000});
    @(posedge clk); #5;
    check("R2 after edge", outs(), {1'b1,1'b0,1'b1,4'b1111,4'b0000});

    // R5, R4: pin inputs and rxPin ignored in local loopback
    @(negedge clk); modemReq = 4'b1010;
    modemPinIn = 4'b0000; rxPin = 1'b0;
    #2 check("R5 pins ignored a", outs(), {1'b1,1'b0,1'b1,4'b1111,4'b1010});
    modemPinIn = 4'b1111; rxPin = 1'b1;
    #2 check("R5 pins ignored b", outs(), {1'b1,1'b0,1'b1,4'b1111,4'b1010});
    txShift = 1'b1;
    #2 check("R4 rx follows tx", outs(), {1'b1,1'b1,1'b1,4'b1111,4'b1010});

    // R6: remote loopback ignores txShift, rx held idle
    @(negedge clk); setMode(3'b010); modemReq = 4'b0000;
    @(posedge clk); @(negedge clk);
    rxPin = 1'b0; txShift = 1'b1;
    #2 check("R6 echo low", outs(), {1'b0,1'b1,1'b0,4'b1111,4'b0000});
    txShift = 1'b0;
    #2 check("R6 tx ignored", outs(), {1'b0,1'b1,1'b0,4'b1111,4'b0000});

    // R7: echo, switch from remote at the same edge as data change
    @(negedge clk); setMode(3'b001); rxPin = 1'b1;
    #2 check("R7 still remote", outs(), {1'b1,1'b1,1'b0,4'b1111,4'b0000});
    @(posedge clk); #5;
    check("R7 echo active", outs(), {1'b1,1'b1,1'b1,4'b1111,4'b0000});

    // R1: reset mid-run returns to normal
    @(negedge clk); setMode(3'b100); @(posedge clk); @(negedge clk);
    rstN = 1'b0; #2;
    check("R1 async reset", outs(), {1'b0,1'b1,1'b1,4'b1111,4'b0000});
    rstN = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule